// File: doc/BRIEF.md
# CMOS Index/Data Register Bank

This block is a 128-byte battery-backed RAM that also hosts four real-time-clock control and status registers. A host reaches every byte through a two-location byte port. A write to location 0 latches a 7-bit index. An access to location 1 reads or writes the byte that the index selects. Most bytes are plain storage. The four control bytes at indices 10 to 13 follow their own rules: a status bit the host cannot write, a set mode that drops two bits, flag bits that clear when read, and read-only bytes.

Time-keeping logic outside the block drives side-band inputs. These raise interrupt flags and the interrupt request, and they mark the start and end of each update window. A sequential checksum engine keeps a 16-bit additive checksum over the configuration bytes 0x10 to 0x2D. Any host write into that range starts the engine. It walks the range one byte per clock, then stores the high byte at 0x2E and the low byte at 0x2F.

Top module: `cmos_bank`

## Requirements
- R1: A write with `host_addr`=0 stores `host_wdata[6:0]` as the index on that clock edge. A read with `host_addr`=0 returns 0xFF.
- R2: With `host_addr`=1, a write stores `host_wdata` into the indexed byte for every index outside 10 to 13. A read returns the indexed byte combinationally in the same cycle.
- R3: After reset, control byte A (index 10) reads 0x26, B (11) reads 0x02, C (12) reads 0x00 and D (13) reads 0x80. The index is 0, `irq` is low and `csum_busy` is low.
- R4: Bit 7 of A is the update-in-progress flag, and host writes to A change only bits 6:0. A one-cycle `upd_start` sets bit 7 unless B bit 7 (set mode) is 1. A one-cycle `upd_done` clears bit 7.
- R5: A host write to B with bit 7 = 1 stores the value with bit 4 (update-ended interrupt enable) forced to 0, and it clears A bit 7. While B bit 7 is 1, `upd_start` leaves A bit 7 at 0.
- R6: Host writes to C and to D have no effect on their contents.
- R7: A cycle with `flag_set` nonzero ORs `flag_set[2:0]` into C bits 6:4, sets C bit 7, and drives `irq` high from the next edge.
- R8: A host read of C returns the current value. C becomes 0x00 and `irq` falls at that edge, unless `flag_set` is nonzero in the same cycle. In that case C holds exactly the new flags (with bit 7) and `irq` stays high.
- R9: A host data write to any index from 0x10 to 0x2D starts the checksum walk. When `csum_busy` falls, byte 0x2E holds bits 15:8 and byte 0x2F holds bits 7:0 of the sum of bytes 0x10 to 0x2D.
- R10: `csum_busy` is high for exactly 30 cycles after the triggering edge. A new trigger during the walk restarts the 30-cycle walk from 0x10.
- R11: Data writes outside 0x10 to 0x2D, including writes to 0x2E and 0x2F, do not start the engine. A value written to 0x2E stays readable while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_en | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 1 | 0 = index location, 1 = data location |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational |
| flag_set | input | 3 | Interrupt flags from the time-keeping logic, ORed into C bits 6:4 |
| upd_start | input | 1 | Update window opens; sets A bit 7 |
| upd_done | input | 1 | Update window closes; clears A bit 7 |
| irq | output | 1 | Interrupt request |
| csum_busy | output | 1 | Checksum walk in progress |

## Verification
Read data is combinational, so the bench samples `host_rdata` 2 ns into the strobe cycle, before the edge that applies any read-clear of C. Index writes, data writes, flag inputs and update pulses take effect at the next rising edge, and the bench observes them from the following falling edge. The checksum lands 30 edges after the triggering write. The bench counts `csum_busy` at each falling edge and expects exactly 30 samples before it reads 0x2E and 0x2F. A bounded wait on `csum_busy` guards every checksum read.

// File: rtl/cmos_pkg.sv
package cmos_pkg;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned IX_CTRL_A  = 10;
    localparam int unsigned IX_CTRL_B  = 11;
    localparam int unsigned IX_CTRL_C  = 12;
    localparam int unsigned IX_CTRL_D  = 13;

    localparam int unsigned A_UIP_BIT  = 7;
    localparam int unsigned B_SET_BIT  = 7;
    localparam int unsigned B_UIE_BIT  = 4;
    localparam int unsigned C_IRQ_BIT  = 7;
    localparam int unsigned FLAG_W     = 3;
    localparam int unsigned FLAG_LSB   = 4;

    localparam logic [BYTE_W-1:0] RST_A = 8'h26;
    localparam logic [BYTE_W-1:0] RST_B = 8'h02;
    localparam logic [BYTE_W-1:0] RST_C = 8'h00;
    localparam logic [BYTE_W-1:0] RST_D = 8'h80;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        byte_t a;
        byte_t b;
        byte_t c;
        byte_t d;
        logic  irq;
    } ctl_state_t;
endpackage

// File: rtl/cmos_csum_engine.sv
module cmos_csum_engine #(
    parameter int unsigned IDX_W = 7,
    parameter int unsigned FIRST = 16,
    parameter int unsigned LAST  = 45,
    parameter int unsigned SUM_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       trig,
    input  logic [cmos_pkg::BYTE_W-1:0] byte_in,
    output logic [IDX_W-1:0]           rd_ptr,
    output logic                       busy,
    output logic                       commit,
    output logic [SUM_W-1:0]           sum
);
    localparam logic [IDX_W-1:0] P_FIRST = IDX_W'(FIRST);
    localparam logic [IDX_W-1:0] P_LAST  = IDX_W'(LAST);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] ptr;
        logic [SUM_W-1:0] acc;
    } eng_t;

    eng_t st_q, st_d;

    always_comb begin
        st_d   = st_q;
        commit = 1'b0;
        sum    = st_q.acc + SUM_W'(byte_in);
        if (trig) begin
            st_d.busy = 1'b1;
            st_d.ptr  = P_FIRST;
            st_d.acc  = '0;
        end else if (st_q.busy) begin
            st_d.acc = sum;
            if (st_q.ptr == P_LAST) begin
                st_d.busy = 1'b0;
                commit    = 1'b1;
            end else begin
                st_d.ptr = st_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_ptr = st_q.ptr;
    assign busy   = st_q.busy;

    // R10
    trig_starts_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> busy);

    // R9
    walk_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !trig && rd_ptr == P_LAST) |=> !busy);

    // R11
    idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !trig) |=> !busy);
endmodule

// File: rtl/cmos_status_regs.sv
module cmos_status_regs
    import cmos_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_a,
    input  logic              wr_b,
    input  logic              rd_c,
    input  byte_t             wdata,
    input  logic              upd_start,
    input  logic              upd_done,
    input  logic [FLAG_W-1:0] flag_set,
    output byte_t             reg_a,
    output byte_t             reg_b,
    output byte_t             reg_c,
    output byte_t             reg_d,
    output logic              irq
);
    ctl_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (wr_a) begin
            st_d.a = {st_q.a[A_UIP_BIT], wdata[A_UIP_BIT-1:0]};
        end
        if (wr_b) begin
            st_d.b = wdata;
            if (wdata[B_SET_BIT]) begin
                st_d.b[B_UIE_BIT] = 1'b0;
                st_d.a[A_UIP_BIT] = 1'b0;
            end
        end
        if (upd_start && !st_d.b[B_SET_BIT]) begin
            st_d.a[A_UIP_BIT] = 1'b1;
        end
        if (upd_done) begin
            st_d.a[A_UIP_BIT] = 1'b0;
        end
        if (rd_c) begin
            st_d.c   = '0;
            st_d.irq = 1'b0;
        end
        if (|flag_set) begin
            st_d.c[FLAG_LSB +: FLAG_W] = st_d.c[FLAG_LSB +: FLAG_W] | flag_set;
            st_d.c[C_IRQ_BIT]          = 1'b1;
            st_d.irq                   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.a   <= RST_A;
            st_q.b   <= RST_B;
            st_q.c   <= RST_C;
            st_q.d   <= RST_D;
            st_q.irq <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_a = st_q.a;
    assign reg_b = st_q.b;
    assign reg_c = st_q.c;
    assign reg_d = st_q.d;
    assign irq   = st_q.irq;

    // R4
    uip_host_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_a && !wr_b && !upd_start && !upd_done) |=> (reg_a[A_UIP_BIT] == $past(reg_a[A_UIP_BIT])));

    // R5
    set_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_b && wdata[B_SET_BIT] && !upd_start) |=> (!reg_b[B_UIE_BIT] && !reg_a[A_UIP_BIT]));

    // R7
    flag_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|flag_set) |=> (irq && reg_c[C_IRQ_BIT]));

    // R8
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_c && flag_set == '0) |=> (reg_c == '0 && !irq));
endmodule

// File: rtl/cmos_bank.sv
module cmos_bank
    import cmos_pkg::*;
#(
    parameter int unsigned IDX_W      = 7,
    parameter int unsigned CSUM_FIRST = 16,
    parameter int unsigned CSUM_LAST  = 45,
    parameter int unsigned CSUM_HI    = 46,
    parameter int unsigned CSUM_LO    = 47,
    parameter int unsigned SUM_W      = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_en,
    input  logic        host_wr,
    input  logic        host_addr,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    input  logic [2:0]  flag_set,
    input  logic        upd_start,
    input  logic        upd_done,
    output logic        irq,
    output logic        csum_busy
);
    localparam int unsigned DEPTH = 1 << IDX_W;
    localparam logic [IDX_W-1:0] X_A  = IDX_W'(IX_CTRL_A);
    localparam logic [IDX_W-1:0] X_B  = IDX_W'(IX_CTRL_B);
    localparam logic [IDX_W-1:0] X_C  = IDX_W'(IX_CTRL_C);
    localparam logic [IDX_W-1:0] X_D  = IDX_W'(IX_CTRL_D);
    localparam logic [IDX_W-1:0] X_LO = IDX_W'(CSUM_FIRST);
    localparam logic [IDX_W-1:0] X_HI = IDX_W'(CSUM_LAST);
    localparam logic [IDX_W-1:0] X_SH = IDX_W'(CSUM_HI);
    localparam logic [IDX_W-1:0] X_SL = IDX_W'(CSUM_LO);

    logic [IDX_W-1:0] idx_q, idx_d;
    byte_t            mem_q [DEPTH];
    byte_t            mem_d [DEPTH];

    logic data_wr, data_rd, idx_wr, is_ctrl, trig, commit;
    logic wr_a, wr_b, rd_c;
    logic [IDX_W-1:0] walk_ptr;
    logic [SUM_W-1:0] walk_sum;
    byte_t reg_a, reg_b, reg_c, reg_d;

    assign idx_wr  = host_en && host_wr && !host_addr;
    assign data_wr = host_en && host_wr && host_addr;
    assign data_rd = host_en && !host_wr && host_addr;
    assign is_ctrl = (idx_q >= X_A) && (idx_q <= X_D);
    assign wr_a    = data_wr && (idx_q == X_A);
    assign wr_b    = data_wr && (idx_q == X_B);
    assign rd_c    = data_rd && (idx_q == X_C);
    assign trig    = data_wr && (idx_q >= X_LO) && (idx_q <= X_HI);

    cmos_status_regs u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_a      (wr_a),
        .wr_b      (wr_b),
        .rd_c      (rd_c),
        .wdata     (host_wdata),
        .upd_start (upd_start),
        .upd_done  (upd_done),
        .flag_set  (flag_set),
        .reg_a     (reg_a),
        .reg_b     (reg_b),
        .reg_c     (reg_c),
        .reg_d     (reg_d),
        .irq       (irq)
    );

    cmos_csum_engine #(
        .IDX_W (IDX_W),
        .FIRST (CSUM_FIRST),
        .LAST  (CSUM_LAST),
        .SUM_W (SUM_W)
    ) u_csum (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig    (trig),
        .byte_in (mem_q[walk_ptr]),
        .rd_ptr  (walk_ptr),
        .busy    (csum_busy),
        .commit  (commit),
        .sum     (walk_sum)
    );

    always_comb begin
        idx_d = idx_q;
        mem_d = mem_q;
        if (idx_wr) begin
            idx_d = host_wdata[IDX_W-1:0];
        end
        if (data_wr && !is_ctrl) begin
            mem_d[idx_q] = host_wdata;
        end
        if (commit) begin
            mem_d[X_SH] = walk_sum[SUM_W-1 -: BYTE_W];
            mem_d[X_SL] = walk_sum[BYTE_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            idx_q <= idx_d;
            mem_q <= mem_d;
        end
    end

    always_comb begin
        if (!host_addr) begin
            host_rdata = 8'hFF;
        end else if (idx_q == X_A) begin
            host_rdata = reg_a;
        end else if (idx_q == X_B) begin
            host_rdata = reg_b;
        end else if (idx_q == X_C) begin
            host_rdata = reg_c;
        end else if (idx_q == X_D) begin
            host_rdata = reg_d;
        end else begin
            host_rdata = mem_q[idx_q];
        end
    end

    // R1
    index_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> (idx_q == $past(host_wdata[IDX_W-1:0])));

    // R6
    ctrl_c_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && idx_q == X_C && flag_set == '0) |=> $stable(reg_c));

    // R9
    csum_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (mem_q[X_SL] == $past(walk_sum[BYTE_W-1:0])));
endmodule

// File: tb/tb_cmos_bank.sv
module tb_cmos_bank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_en = 1'b0, host_wr = 1'b0, host_addr = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic [2:0] flag_set = 3'b000;
    logic       upd_start = 1'b0, upd_done = 1'b0;
    logic       irq, csum_busy;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] model [128];

    always #4 clk = ~clk;

    cmos_bank dut (
        .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .flag_set(flag_set), .upd_start(upd_start), .upd_done(upd_done),
        .irq(irq), .csum_busy(csum_busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus(input logic wr, input logic a, input logic [7:0] d, output logic [7:0] r);
        host_en = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
        #2 r = host_rdata;
        @(negedge clk);
        host_en = 1'b0; host_wr = 1'b0;
    endtask

    task automatic wr_reg(input int ix, input logic [7:0] v);
        logic [7:0] r;
        bus(1'b1, 1'b0, 8'(ix), r);
        bus(1'b1, 1'b1, v, r);
    endtask

    task automatic rd_reg(input int ix, output logic [7:0] v);
        logic [7:0] r;
        bus(1'b1, 1'b0, 8'(ix), r);
        bus(1'b0, 1'b1, 8'h00, v);
    endtask

    task automatic pulse_start();
        upd_start = 1'b1; @(negedge clk); upd_start = 1'b0;
    endtask

    task automatic pulse_done();
        upd_done = 1'b1; @(negedge clk); upd_done = 1'b0;
    endtask

    task automatic pulse_flags(input logic [2:0] f);
        flag_set = f; @(negedge clk); flag_set = 3'b000;
    endtask

    function automatic int exp_sum();
        int s = 0;
        for (int i = 16; i <= 45; i++) s += model[i];
        return s & 16'hFFFF;
    endfunction

    task automatic count_busy(output int n);
        n = 0;
        while (csum_busy && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic check_csum(input string req);
        logic [7:0] hi, lo;
        int s;
        s = exp_sum();
        rd_reg(46, hi);
        rd_reg(47, lo);
        check(hi == s[15:8], req, hi, s[15:8]);
        check(lo == s[7:0], req, lo, s[7:0]);
        model[46] = hi; model[47] = lo;
    endtask

    function automatic bit plain_ix(input int ix);
        return !(ix >= 10 && ix <= 13) && ix != 46 && ix != 47;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] r;
        int n;
        for (int i = 0; i < 128; i++) model[i] = 8'h00;
        void'($urandom(32'd7741));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 reset state
        check(irq == 1'b0, "R3 irq", irq, 0);
        check(csum_busy == 1'b0, "R3 busy", csum_busy, 0);
        bus(1'b0, 1'b1, 8'h00, r);
        check(r == 8'h00, "R3 index0 data", r, 0);
        rd_reg(10, r); check(r == 8'h26, "R3 A", r, 8'h26);
        rd_reg(11, r); check(r == 8'h02, "R3 B", r, 8'h02);
        rd_reg(12, r); check(r == 8'h00, "R3 C", r, 8'h00);
        rd_reg(13, r); check(r == 8'h80, "R3 D", r, 8'h80);

        // R1 even read, index masking
        bus(1'b0, 1'b0, 8'h00, r);
        check(r == 8'hFF, "R1 even read", r, 8'hFF);
        wr_reg(8'h85, 8'h5A);
        rd_reg(5, r);
        check(r == 8'h5A, "R1 index low 7 bits", r, 8'h5A);
        model[5] = 8'h5A;

        // R2 round trip at both ends
        wr_reg(0, 8'h3C); model[0] = 8'h3C;
        wr_reg(127, 8'hC3); model[127] = 8'hC3;
        rd_reg(0, r); check(r == 8'h3C, "R2 byte 0", r, 8'h3C);
        rd_reg(127, r); check(r == 8'hC3, "R2 byte 127", r, 8'hC3);

        // R4 read-only update flag
        wr_reg(10, 8'hFF);
        rd_reg(10, r); check(r == 8'h7F, "R4 host cannot set bit7", r, 8'h7F);
        pulse_start();
        rd_reg(10, r); check(r == 8'hFF, "R4 upd_start sets bit7", r, 8'hFF);
        wr_reg(10, 8'h26);
        rd_reg(10, r); check(r == 8'hA6, "R4 host cannot clear bit7", r, 8'hA6);
        pulse_done();
        rd_reg(10, r); check(r == 8'h26, "R4 upd_done clears bit7", r, 8'h26);

        // R5 set mode
        pulse_start();
        wr_reg(11, 8'h92);
        rd_reg(11, r); check(r == 8'h82, "R5 UIE dropped", r, 8'h82);
        rd_reg(10, r); check(r == 8'h26, "R5 UIP cleared", r, 8'h26);
        pulse_start();
        rd_reg(10, r); check(r == 8'h26, "R5 no UIP in set mode", r, 8'h26);
        wr_reg(11, 8'h12);
        rd_reg(11, r); check(r == 8'h12, "R5 UIE kept without set", r, 8'h12);

        // R6 C and D read-only
        wr_reg(12, 8'hFF);
        rd_reg(12, r); check(r == 8'h00, "R6 C write ignored", r, 8'h00);
        check(irq == 1'b0, "R6 irq after C write", irq, 0);
        wr_reg(13, 8'h00);
        rd_reg(13, r); check(r == 8'h80, "R6 D write ignored", r, 8'h80);

        // R7 flag set and irq
        pulse_flags(3'b100);
        check(irq == 1'b1, "R7 irq raised", irq, 1);
        rd_reg(12, r); check(r == 8'hC0, "R7 periodic flag", r, 8'hC0);
        // R8 cleared by that read
        check(irq == 1'b0, "R8 irq dropped", irq, 0);
        rd_reg(12, r); check(r == 8'h00, "R8 C cleared", r, 8'h00);

        // R8 read-clear racing a new flag
        pulse_flags(3'b010);
        bus(1'b1, 1'b0, 8'd12, r);
        host_en = 1'b1; host_wr = 1'b0; host_addr = 1'b1; flag_set = 3'b001;
        #2 r = host_rdata;
        @(negedge clk);
        host_en = 1'b0; flag_set = 3'b000;
        check(r == 8'hA0, "R8 read returns old", r, 8'hA0);
        check(irq == 1'b1, "R8 new flag keeps irq", irq, 1);
        bus(1'b0, 1'b1, 8'h00, r);
        check(r == 8'h90, "R8 new flag survives", r, 8'h90);
        check(irq == 1'b0, "R8 irq after second read", irq, 0);

        // R11 writes outside the range
        wr_reg(48, 8'h11); model[48] = 8'h11;
        check(csum_busy == 1'b0, "R11 no trigger at 0x30", csum_busy, 0);
        wr_reg(46, 8'h77);
        check(csum_busy == 1'b0, "R11 no trigger at 0x2E", csum_busy, 0);
        rd_reg(46, r); check(r == 8'h77, "R11 0x2E holds", r, 8'h77);

        // R9 / R10 single trigger
        wr_reg(16, 8'hFF); model[16] = 8'hFF;
        count_busy(n);
        check(n == 30, "R10 busy length", n, 30);
        check_csum("R9 checksum single");

        // R10 restart while busy
        wr_reg(45, 8'hF0); model[45] = 8'hF0;
        repeat (10) @(negedge clk);
        wr_reg(17, 8'h81); model[17] = 8'h81;
        count_busy(n);
        check(n == 30, "R10 restart length", n, 30);
        check_csum("R9 checksum after restart");

        // R2 / R9 random traffic
        for (int k = 0; k < 200; k++) begin
            int ix;
            logic [7:0] v;
            ix = $urandom % 128;
            while (!plain_ix(ix)) ix = $urandom % 128;
            v = 8'($urandom);
            wr_reg(ix, v);
            model[ix] = v;
            if (k % 8 == 0) begin
                rd_reg(ix, r);
                check(r == v, "R2 random readback", r, v);
            end
        end
        wr_reg(30, 8'hEE); model[30] = 8'hEE;
        count_busy(n);
        check(n == 30, "R10 busy after random", n, 30);
        check_csum("R9 checksum random");
        for (int i = 0; i < 128; i++) begin
            if (plain_ix(i)) begin
                rd_reg(i, r);
                check(r == model[i], "R2 final sweep", r, model[i]);
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule